// File: doc/BRIEF.md
# DS3 Application Identification Detector

This block tells a receiver whether an incoming DS3 stream carries C-bit parity framing or M23 framing. Once per M-frame, upstream framing logic hands it the application identification bit. That bit is the first C bit of M-subframe 1. In C-bit parity streams the bit sits at 1. In M23 streams it is a stuff-control bit, so it changes from frame to frame.

The detector counts M-frames in fixed, non-overlapping windows, 1024 frames by default, which is about 109 ms. It also counts how many of those frames carried a 1. At the end of each window it compares the count of ones against a threshold, 1020 by default, and updates a real-time status bit. The status is 1 for C-bit parity and 0 otherwise. It is not latched. In E3 mode the result has no meaning, so the counters are held cleared and the status is forced low.

Top module: `aic_app_detect`

## Requirements
- R1: After reset, `cbit_parity` is 0 and stays 0 until the first complete window has ended.
- R2: When a window ends with at least `THRESH` ones among its `WINDOW` frames, `cbit_parity` becomes 1 one clock after the strobe of the window's last frame.
- R3: When a window ends with fewer than `THRESH` ones, `cbit_parity` becomes 0 one clock after the strobe of the window's last frame.
- R4: `cbit_parity` changes only in the cycle after a window's last strobe, or when E3 mode is selected. It holds its value through the earlier frames of each window.
- R5: Windows do not overlap. Both counts restart from zero after every window, so each decision depends only on the `WINDOW` frames of its own window.
- R6: While `mode_ds3` is 0 (E3), `cbit_parity` reads 0 from the next clock and any partial window is discarded. After a return to DS3, the next decision comes after `WINDOW` fresh strobes.
- R7: A value on `aic_bit` in a cycle without `frame_stb` has no effect on any count or on the status.
- R8: An alternating AIC pattern, as an M23 stream gives, yields `cbit_parity` = 0 for any `THRESH` above `WINDOW`/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ds3 | input | 1 | 1 = DS3 operation, 0 = E3 (detector idle) |
| frame_stb | input | 1 | One-cycle pulse, once per received M-frame |
| aic_bit | input | 1 | Application identification bit, valid with `frame_stb` |
| cbit_parity | output | 1 | Live decision: 1 = C-bit parity format detected |

## Verification
The assertions assume that `frame_stb` marks each M-frame with a single cycle. They also assume that `aic_bit` only matters in strobe cycles, and that `mode_ds3` may change at any clock.

The bench drives one-cycle strobes separated by idle cycles. During those idle cycles it puts the inverse of the frame's bit on `aic_bit`, so that any sampling outside a strobe would skew the counts. It switches the mode in the middle of a window to exercise the discard path. With a small window, every possible ones count is swept.

// File: rtl/aic_pkg.sv
package aic_pkg;

  // Next value of a window count: cleared, advanced by one, or held.
  function automatic int unsigned aic_step(input int unsigned cur,
                                           input bit clr,
                                           input bit inc);
    if (clr) return 0;
    if (inc) return cur + 1;
    return cur;
  endfunction

  // Window verdict: the ones seen so far plus the closing frame's bit,
  // compared against the threshold.
  function automatic bit aic_verdict(input int unsigned ones_so_far,
                                     input bit last_bit,
                                     input int unsigned thresh);
    return (ones_so_far + (last_bit ? 1 : 0)) >= thresh;
  endfunction

endpackage

// File: rtl/aic_counter.sv
module aic_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  import aic_pkg::*;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = W'(aic_step(int'(cnt), clr, inc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/aic_decider.sv
module aic_decider #(
  parameter int unsigned W      = 11,
  parameter int unsigned THRESH = 1020
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_ds3,
  input  logic         win_end,
  input  logic [W-1:0] ones_cnt,
  input  logic         last_bit,
  output logic         status
);
  import aic_pkg::*;

  logic verdict;

  always_comb begin
    verdict = aic_verdict(int'(ones_cnt), last_bit, THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= 1'b0;
    else if (!mode_ds3) status <= 1'b0;
    else if (win_end)  status <= verdict;
  end
endmodule

// File: rtl/aic_app_detect.sv
module aic_app_detect #(
  parameter int unsigned WINDOW = 1024,
  parameter int unsigned THRESH = 1020
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ds3,
  input  logic frame_stb,
  input  logic aic_bit,
  output logic cbit_parity
);
  localparam int unsigned CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] frm_cnt;
  logic [CNT_W-1:0] ones_cnt;
  logic             frame_seen;
  logic             one_seen;
  logic             win_end;
  logic             cnt_clr;

  assign frame_seen = mode_ds3 && frame_stb;
  assign one_seen   = frame_seen && aic_bit;
  assign win_end    = frame_seen && (frm_cnt == LAST_IDX);
  assign cnt_clr    = win_end || !mode_ds3;

  aic_counter #(.W(CNT_W)) frm_ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(frame_seen), .cnt(frm_cnt)
  );

  aic_counter #(.W(CNT_W)) ones_ctr_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(one_seen), .cnt(ones_cnt)
  );

  aic_decider #(.W(CNT_W), .THRESH(THRESH)) dec_i (
    .clk(clk), .rst_n(rst_n), .mode_ds3(mode_ds3), .win_end(win_end),
    .ones_cnt(ones_cnt), .last_bit(aic_bit), .status(cbit_parity)
  );
endmodule

// File: rtl/aic_app_detect_chk.sv
module aic_app_detect_chk #(
  parameter int unsigned WINDOW = 1024,
  parameter int unsigned THRESH = 1020,
  parameter int unsigned CNT_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_ds3,
  input logic             frame_stb,
  input logic             aic_bit,
  input logic             cbit_parity,
  input logic             win_end,
  input logic [CNT_W-1:0] frm_cnt,
  input logic [CNT_W-1:0] ones_cnt
);
  logic [CNT_W:0] closing_ones;
  assign closing_ones = {1'b0, ones_cnt} + {{CNT_W{1'b0}}, aic_bit};

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && (closing_ones >= (CNT_W+1)'(THRESH)) |=> cbit_parity);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && (closing_ones < (CNT_W+1)'(THRESH)) |=> !cbit_parity);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ds3 && !win_end |=> $stable(cbit_parity));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (frm_cnt == '0) && (ones_cnt == '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_cnt <= frm_cnt) && (frm_cnt < CNT_W'(WINDOW)));

  assert_e3_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ds3 |=> !cbit_parity && (frm_cnt == '0) && (ones_cnt == '0));

  assert_ignore_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ds3 && !frame_stb |=> $stable(frm_cnt) && $stable(ones_cnt));
endmodule

bind aic_app_detect aic_app_detect_chk #(
  .WINDOW(WINDOW), .THRESH(THRESH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_ds3(mode_ds3), .frame_stb(frame_stb),
  .aic_bit(aic_bit), .cbit_parity(cbit_parity), .win_end(win_end),
  .frm_cnt(frm_cnt), .ones_cnt(ones_cnt)
);

// File: tb/aic_app_detect_tb_top.sv
module aic_app_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;
  localparam int THR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ds3 = 1'b1;
  logic frame_stb = 1'b0;
  logic aic_bit = 1'b0;
  logic cbit_parity;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aic_app_detect #(.WINDOW(WIN), .THRESH(THR)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ds3(mode_ds3), .frame_stb(frame_stb),
    .aic_bit(aic_bit), .cbit_parity(cbit_parity)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (cbit_parity !== exp) begin
      bad++;
      $display("FAIL %s: cbit_parity=%0b expected=%0b", req, cbit_parity, exp);
    end
  endtask

  // One strobe, then one idle cycle with the inverse bit on aic_bit.
  task automatic send_frame(input logic b);
    @(negedge clk);
    frame_stb = 1'b1;
    aic_bit   = b;
    @(negedge clk);
    frame_stb = 1'b0;
    aic_bit   = ~b;
  endtask

  // Send a window whose first k frames carry 1. Check that the status holds
  // through the window, then check the decision.
  task automatic send_window(input int k, input logic prev, input string req);
    for (int i = 0; i < WIN; i++) begin
      send_frame(i < k);
      if (i == WIN - 2) check("R4", prev);
    end
    @(negedge clk);
    check(req, (k >= THR));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // Full sweep of the ones count (R2, R3), each window decided alone (R5).
    prev = 1'b0;
    for (int k = 0; k <= WIN; k++) begin
      send_window(k, prev, (k >= THR) ? "R2" : "R3");
      prev = (k >= THR);
    end

    // A high window followed by a low one: no carry-over between windows.
    send_window(WIN, prev, "R5");
    send_window(THR - 1, 1'b1, "R5");

    // An alternating pattern, as an M23 stream gives.
    send_window(WIN, 1'b0, "R2");
    for (int i = 0; i < WIN; i++) send_frame(i % 2);
    @(negedge clk);
    check("R8", 1'b0);

    // Idle cycles with aic_bit=1 must not count: one strobe of 1 only.
    send_window(WIN, 1'b0, "R2");
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      frame_stb = 1'b1;
      aic_bit   = (i == 0);
      @(negedge clk);
      frame_stb = 1'b0;
      aic_bit   = 1'b1;
      repeat (2) @(negedge clk);
    end
    aic_bit = 1'b0;
    check("R7", 1'b0);

    // E3 mid-window: status forced low and the partial window discarded.
    send_window(WIN, 1'b0, "R2");
    for (int i = 0; i < 5; i++) send_frame(1'b1);
    mode_ds3 = 1'b0;
    @(negedge clk);
    check("R6", 1'b0);
    send_frame(1'b1);
    send_frame(1'b1);
    mode_ds3 = 1'b1;
    for (int i = 0; i < WIN - 1; i++) send_frame(1'b1);
    @(negedge clk);
    check("R6", 1'b0);
    send_frame(1'b1);
    @(negedge clk);
    check("R6", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule